// File: doc/BRIEF.md
# SCSI Selection Response Qualifier

This block watches the parallel SCSI bus while the device is idle. It decides whether a SELECTION or a RESELECTION phase is addressed to this device. A phase is recognised when SEL is asserted and no other device drives BSY. The I/O line tells the two kinds apart: low means selection and high means reselection. Bus lines can be skewed, so the block waits for a programmable settle time before it samples the data bus. It then applies three checks to the sample: the bit for the device's own ID must be set, no more than a fixed number of data bits may be set, and the parity bit must be correct when parity checking is on.

When the checks pass, the block drives BSY. It takes the target role after a selection and the initiator role after a reselection, and it gives a one-cycle event pulse for each. The target role lasts until a bus-release command arrives. The initiator role lasts until the bus goes free (a disconnect). A bus reset ends either role. While the interrupt logic reports a pending disconnect or reset-condition interrupt, the block gives no response. The sampled bus value is kept in a temp register that software can read.

All pins are plain control and status signals. No data flows as a stream, so no pin uses a valid/ready handshake.

Top module: `scsi_sel_qualifier`

## Requirements
- R1: After reset, role is idle (code 2'b00), drive_bsy is low, temp_data is zero and no event pulse is high.
- R2: A phase is accepted only if bit own_id of bus_data is set.
- R3: A phase is accepted only if at most MAX_SET (default 2) bits of bus_data are set; bus_dp is not counted.
- R4: When parity_en is high, a phase is accepted only if bus_data together with bus_dp holds an odd number of ones. When parity_en is low, bus_dp is ignored.
- R5: Each time a phase is sampled, temp_data takes the value of bus_data, whether or not the phase is accepted.
- R6: Sampling happens at the clock edge at which the phase condition (bus_sel high, bus_bsy_in low, bus_io unchanged) has held for settle_cycles+1 consecutive edges. The role, drive_bsy and the event pulse change at that edge, and the event is high for exactly one cycle.
- R7: An accepted phase with bus_io low gives a pulse on evt_selected and sets role to target (2'b01). drive_bsy stays high until cmd_release is seen; the block then returns to idle.
- R8: An accepted phase with bus_io high gives a pulse on evt_reselected and sets role to initiator (2'b10). drive_bsy is held only while bus_sel stays high. Afterwards, seeing bus_sel and bus_bsy_in both low gives a pulse on evt_disconnect and returns role to idle. cmd_release has no effect in this role.
- R9: While disc_pending or rst_pending is high, no phase is sampled: temp_data, role and the events stay unchanged.
- R10: While bus_rst is high, drive_bsy is low in the same cycle and role is idle from the next edge. A rising bus_rst gives one pulse on evt_bus_reset.
- R11: A phase is sampled at most once. Until bus_sel drops, a changed bus_data is not sampled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| own_id | input | 3 | Device ID; selects the data bit to match |
| parity_en | input | 1 | Enables the odd-parity check |
| settle_cycles | input | 4 | Number of extra stable edges before sampling |
| bus_sel | input | 1 | SEL as seen on the bus |
| bus_bsy_in | input | 1 | BSY driven by other devices |
| bus_io | input | 1 | I/O line: 0 selection, 1 reselection |
| bus_rst | input | 1 | RST as seen on the bus |
| bus_data | input | 8 | Data bus |
| bus_dp | input | 1 | Data parity bit |
| cmd_release | input | 1 | Bus-release command pulse |
| disc_pending | input | 1 | Disconnect interrupt still pending |
| rst_pending | input | 1 | Reset-condition interrupt still pending |
| drive_bsy | output | 1 | BSY drive enable toward the bus |
| role | output | 2 | 00 idle, 01 target, 10 initiator |
| temp_data | output | 8 | Last sampled bus value |
| evt_selected | output | 1 | Selected event pulse |
| evt_reselected | output | 1 | Reselected event pulse |
| evt_disconnect | output | 1 | Disconnect event pulse |
| evt_bus_reset | output | 1 | Bus reset event pulse |

## Verification
The assertions assume that own_id, parity_en and settle_cycles are held steady for the whole of a phase. They also assume that cmd_release is a short pulse, and that in the initiator role the bus goes free only after our BSY has been released. The stimulus meets these assumptions. It sets the configuration and the data bus at least two cycles before raising bus_sel. It lowers bus_sel before it changes any pending flag. It releases a role only through the sequence that role expects.

// File: rtl/selq_pkg.sv
package selq_pkg;
  typedef enum logic [1:0] {
    ROLE_IDLE   = 2'b00,
    ROLE_TARGET = 2'b01,
    ROLE_INIT   = 2'b10
  } role_e;
endpackage

// File: rtl/selq_phase_detect.sv
// Recognises a selection/reselection phase and issues one sample strobe
// after the bus has been stable for the programmed settle time.
module selq_phase_detect #(
  parameter int SETTLE_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_bsy_in,
  input  logic                bus_io,
  input  logic                bus_rst,
  input  logic                role_idle,
  input  logic                bsy_held,
  input  logic                hold_disc,
  input  logic                hold_rst,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic                sample_stb
);
  logic [SETTLE_W-1:0] cnt_q;
  logic                armed_q;
  logic                io_q;
  logic                phase_on;
  logic                io_steady;

  assign phase_on  = bus_sel & ~bus_bsy_in & ~bus_rst & role_idle & ~bsy_held
                   & ~hold_disc & ~hold_rst;
  assign io_steady = (bus_io == io_q);
  assign sample_stb = phase_on & io_steady & armed_q & (cnt_q == settle_cycles);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
      io_q    <= 1'b0;
    end else begin
      io_q <= bus_io;
      if (!phase_on) begin
        cnt_q   <= '0;
        armed_q <= 1'b1;
      end else if (!io_steady) begin
        cnt_q <= '0;
      end else if (armed_q) begin
        if (cnt_q == settle_cycles) armed_q <= 1'b0;
        else                        cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

  // R11
  one_sample_per_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);
endmodule

// File: rtl/selq_match_check.sv
// Combinational address, bit-count and parity qualification of a sample.
module selq_match_check #(
  parameter int DATA_W  = 8,
  parameter int MAX_SET = 2,
  localparam int ID_W   = $clog2(DATA_W),
  localparam int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] data,
  input  logic              dp,
  input  logic [ID_W-1:0]   own_id,
  input  logic              parity_en,
  output logic              accept
);
  logic [CNT_W-1:0] ones;
  logic             id_hit;
  logic             count_ok;
  logic             parity_ok;

  always_comb begin
    ones = '0;
    for (int i = 0; i < DATA_W; i++) ones = ones + CNT_W'(data[i]);
  end

  assign id_hit    = data[own_id];
  assign count_ok  = (ones <= CNT_W'(MAX_SET));
  assign parity_ok = ~parity_en | (^{data, dp});
  assign accept    = id_hit & count_ok & parity_ok;

  // R2
  id_bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> data[own_id]);
  // R3
  bit_count_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ($countones(data) <= MAX_SET));
  // R4
  odd_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && parity_en) |-> ($countones({data, dp}) % 2 == 1));
endmodule

// File: rtl/selq_role_fsm.sv
// Holds the role, the BSY drive, the temp register and the event pulses.
module selq_role_fsm
  import selq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_stb,
  input  logic              accept,
  input  logic [DATA_W-1:0] data,
  input  logic              bus_io,
  input  logic              bus_sel,
  input  logic              bus_bsy_in,
  input  logic              bus_rst,
  input  logic              cmd_release,
  output role_e             role_q,
  output logic              bsy_q,
  output logic [DATA_W-1:0] temp_q,
  output logic              evt_sel_q,
  output logic              evt_resel_q,
  output logic              evt_disc_q,
  output logic              evt_rst_q
);
  logic rst_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      role_q      <= ROLE_IDLE;
      bsy_q       <= 1'b0;
      temp_q      <= '0;
      evt_sel_q   <= 1'b0;
      evt_resel_q <= 1'b0;
      evt_disc_q  <= 1'b0;
      evt_rst_q   <= 1'b0;
      rst_seen_q  <= 1'b0;
    end else begin
      evt_sel_q   <= 1'b0;
      evt_resel_q <= 1'b0;
      evt_disc_q  <= 1'b0;
      evt_rst_q   <= 1'b0;
      rst_seen_q  <= bus_rst;
      if (bus_rst) begin
        role_q    <= ROLE_IDLE;
        bsy_q     <= 1'b0;
        evt_rst_q <= ~rst_seen_q;
      end else begin
        unique case (role_q)
          ROLE_IDLE: begin
            if (sample_stb) begin
              temp_q <= data;
              if (accept) begin
                bsy_q <= 1'b1;
                if (bus_io) begin
                  role_q      <= ROLE_INIT;
                  evt_resel_q <= 1'b1;
                end else begin
                  role_q    <= ROLE_TARGET;
                  evt_sel_q <= 1'b1;
                end
              end
            end
          end
          ROLE_TARGET: begin
            if (cmd_release) begin
              role_q <= ROLE_IDLE;
              bsy_q  <= 1'b0;
            end
          end
          ROLE_INIT: begin
            if (bsy_q) begin
              if (!bus_sel) bsy_q <= 1'b0;
            end else if (!bus_sel && !bus_bsy_in) begin
              role_q     <= ROLE_IDLE;
              evt_disc_q <= 1'b1;
            end
          end
          default: role_q <= ROLE_IDLE;
        endcase
      end
    end
  end

  // R7
  selected_sets_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_sel_q |-> (role_q == ROLE_TARGET && bsy_q));
  // R8
  reselected_sets_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_resel_q |-> (role_q == ROLE_INIT && bsy_q));
  // R8
  disconnect_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_disc_q |-> (role_q == ROLE_IDLE && !bsy_q));
  // R6
  event_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_sel_q || evt_resel_q) |=> !(evt_sel_q || evt_resel_q));
  // R10
  bus_reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> (role_q == ROLE_IDLE && !bsy_q));
endmodule

// File: rtl/scsi_sel_qualifier.sv
module scsi_sel_qualifier
  import selq_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int MAX_SET  = 2,
  parameter int SETTLE_W = 4,
  localparam int ID_W    = $clog2(DATA_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ID_W-1:0]     own_id,
  input  logic                parity_en,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic                bus_sel,
  input  logic                bus_bsy_in,
  input  logic                bus_io,
  input  logic                bus_rst,
  input  logic [DATA_W-1:0]   bus_data,
  input  logic                bus_dp,
  input  logic                cmd_release,
  input  logic                disc_pending,
  input  logic                rst_pending,
  output logic                drive_bsy,
  output logic [1:0]          role,
  output logic [DATA_W-1:0]   temp_data,
  output logic                evt_selected,
  output logic                evt_reselected,
  output logic                evt_disconnect,
  output logic                evt_bus_reset
);
  role_e role_q;
  logic  bsy_q;
  logic  sample_stb;
  logic  accept;

  selq_phase_detect #(.SETTLE_W(SETTLE_W)) u_phase (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_bsy_in(bus_bsy_in), .bus_io(bus_io), .bus_rst(bus_rst),
    .role_idle(role_q == ROLE_IDLE), .bsy_held(bsy_q),
    .hold_disc(disc_pending), .hold_rst(rst_pending),
    .settle_cycles(settle_cycles), .sample_stb(sample_stb)
  );

  selq_match_check #(.DATA_W(DATA_W), .MAX_SET(MAX_SET)) u_match (
    .clk(clk), .rst_n(rst_n),
    .data(bus_data), .dp(bus_dp), .own_id(own_id), .parity_en(parity_en),
    .accept(accept)
  );

  selq_role_fsm #(.DATA_W(DATA_W)) u_role (
    .clk(clk), .rst_n(rst_n),
    .sample_stb(sample_stb), .accept(accept), .data(bus_data),
    .bus_io(bus_io), .bus_sel(bus_sel), .bus_bsy_in(bus_bsy_in), .bus_rst(bus_rst),
    .cmd_release(cmd_release),
    .role_q(role_q), .bsy_q(bsy_q), .temp_q(temp_data),
    .evt_sel_q(evt_selected), .evt_resel_q(evt_reselected),
    .evt_disc_q(evt_disconnect), .evt_rst_q(evt_bus_reset)
  );

  assign drive_bsy = bsy_q & ~bus_rst;
  assign role      = role_q;

  // R9
  pending_blocks_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disc_pending || rst_pending) |=> !(evt_selected || evt_reselected));
  // R10
  reset_drops_bsy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |-> !drive_bsy);
endmodule

// File: tb/test_scsi_sel_qualifier.sv
`timescale 1ns/1ps
module test_scsi_sel_qualifier;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] own_id = 3'd0;
  logic       parity_en = 1'b0;
  logic [3:0] settle_cycles = 4'd0;
  logic       bus_sel = 1'b0, bus_bsy_in = 1'b0, bus_io = 1'b0, bus_rst = 1'b0;
  logic [7:0] bus_data = 8'h00;
  logic       bus_dp = 1'b0, cmd_release = 1'b0;
  logic       disc_pending = 1'b0, rst_pending = 1'b0;
  logic       drive_bsy;
  logic [1:0] role;
  logic [7:0] temp_data;
  logic       evt_selected, evt_reselected, evt_disconnect, evt_bus_reset;

  int n_chk = 0, n_err = 0;
  int n_sel = 0, n_resel = 0, n_disc = 0, n_brst = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  scsi_sel_qualifier i_scsi_sel_qualifier (
    .clk(clk), .rst_n(rst_n), .own_id(own_id), .parity_en(parity_en),
    .settle_cycles(settle_cycles), .bus_sel(bus_sel), .bus_bsy_in(bus_bsy_in),
    .bus_io(bus_io), .bus_rst(bus_rst), .bus_data(bus_data), .bus_dp(bus_dp),
    .cmd_release(cmd_release), .disc_pending(disc_pending), .rst_pending(rst_pending),
    .drive_bsy(drive_bsy), .role(role), .temp_data(temp_data),
    .evt_selected(evt_selected), .evt_reselected(evt_reselected),
    .evt_disconnect(evt_disconnect), .evt_bus_reset(evt_bus_reset)
  );

  always @(negedge clk) begin
    if (evt_selected)   n_sel++;
    if (evt_reselected) n_resel++;
    if (evt_disconnect) n_disc++;
    if (evt_bus_reset)  n_brst++;
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  function automatic bit expect_accept(logic [7:0] d, logic p, logic [2:0] id, logic pe);
    return d[id] && ($countones(d) <= 2) && (!pe || (^{d, p}));
  endfunction

  task automatic setup_bus(logic [2:0] id, logic [7:0] d, logic p, logic pe, logic io, logic [3:0] st);
    own_id = id; bus_data = d; bus_dp = p; parity_en = pe; bus_io = io; settle_cycles = st;
    bus_sel = 1'b0; bus_bsy_in = 1'b0;
    tick(2);
  endtask

  task automatic run_trial(logic [2:0] id, logic [7:0] d, logic p, logic pe, logic io, logic [3:0] st);
    int s0, r0, d0;
    bit ok;
    setup_bus(id, d, p, pe, io, st);
    s0 = n_sel; r0 = n_resel; d0 = n_disc;
    ok = expect_accept(d, p, id, pe);
    bus_sel = 1'b1;
    tick(int'(st) + 4);
    check("R5 temp capture", temp_data, d);
    check("R2/R3/R4/R7 selected count", n_sel - s0, (ok && !io) ? 1 : 0);
    check("R2/R3/R4/R8 reselected count", n_resel - r0, (ok && io) ? 1 : 0);
    check("R7/R8 role", role, !ok ? 0 : (io ? 2 : 1));
    check("R7/R8 drive_bsy", drive_bsy, ok ? 1 : 0);
    if (ok && !io) begin
      bus_sel = 1'b0; tick(2);
      check("R7 target held", role, 1);
      cmd_release = 1'b1; tick(1); cmd_release = 1'b0; tick(1);
      check("R7 release role", role, 0);
      check("R7 release bsy", drive_bsy, 0);
    end else if (ok && io) begin
      bus_bsy_in = 1'b1; bus_sel = 1'b0; tick(2);
      check("R8 bsy dropped", drive_bsy, 0);
      cmd_release = 1'b1; tick(1); cmd_release = 1'b0; tick(1);
      check("R8 release ignored", role, 2);
      bus_bsy_in = 1'b0; tick(2);
      check("R8 disconnect event", n_disc - d0, 1);
      check("R8 disconnect role", role, 0);
    end else begin
      bus_sel = 1'b0; tick(2);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    report();
  end

  initial begin
    logic [7:0] d;
    int s0, b0;
    void'($urandom(32'h5eed));
    tick(3);
    // R1 reset state
    check("R1 role", role, 0);
    check("R1 drive_bsy", drive_bsy, 0);
    check("R1 temp", temp_data, 0);
    check("R1 events", n_sel + n_resel + n_disc + n_brst, 0);
    rst_n = 1'b1;
    tick(2);
    check("R1 events after reset", n_sel + n_resel + n_disc + n_brst, 0);

    // R6 exact sampling edge with settle of 2
    d = 8'b0001_0001;
    setup_bus(3'd4, d, ~^d, 1'b1, 1'b0, 4'd2);
    bus_sel = 1'b1;
    tick(2);
    check("R6 not before settle", role, 0);
    tick(1);
    check("R6 evt at sample edge", evt_selected, 1);
    check("R6 role at sample edge", role, 1);
    tick(1);
    check("R6 single pulse", evt_selected, 0);
    bus_sel = 1'b0; cmd_release = 1'b1; tick(1); cmd_release = 1'b0; tick(1);

    // R9 pending interrupts suppress
    d = 8'b0000_0101;
    setup_bus(3'd2, d, ~^d, 1'b1, 1'b0, 4'd1);
    disc_pending = 1'b1;
    bus_sel = 1'b1; tick(10);
    check("R9 disc pending role", role, 0);
    check("R9 disc pending temp", temp_data, 8'b0001_0001);
    bus_sel = 1'b0; tick(2); disc_pending = 1'b0; rst_pending = 1'b1;
    bus_sel = 1'b1; tick(10);
    check("R9 rst pending role", role, 0);
    check("R9 rst pending bsy", drive_bsy, 0);
    bus_sel = 1'b0; tick(2); rst_pending = 1'b0;

    // R11 single sample per phase
    setup_bus(3'd1, 8'b0000_1000, 1'b0, 1'b0, 1'b0, 4'd0);
    bus_sel = 1'b1; tick(6);
    bus_data = 8'b0000_0010; tick(6);
    check("R11 no resample role", role, 0);
    check("R11 no resample temp", temp_data, 8'b0000_1000);
    bus_sel = 1'b0; tick(2);

    // R4 parity ignored when disabled
    run_trial(3'd6, 8'b0100_0000, 1'b0, 1'b0, 1'b0, 4'd0);
    // R3 three bits rejected
    run_trial(3'd0, 8'b0000_0111, 1'b0, 1'b0, 1'b1, 4'd0);

    // R10 bus reset in target role
    d = 8'b1000_0000;
    setup_bus(3'd7, d, ~^d, 1'b1, 1'b0, 4'd0);
    bus_sel = 1'b1; tick(4);
    check("R10 precondition target", role, 1);
    bus_sel = 1'b0;
    b0 = n_brst;
    bus_rst = 1'b1; #1;
    check("R10 bsy low at once", drive_bsy, 0);
    tick(1);
    check("R10 role idle", role, 0);
    tick(3);
    check("R10 one reset event", n_brst - b0, 1);
    bus_rst = 1'b0; tick(2);

    // random trials
    for (int t = 0; t < 300; t++) begin
      logic [2:0] id;
      logic [7:0] dd;
      logic p;
      id = 3'($urandom % 8);
      dd = 8'h00;
      if (($urandom % 4) != 0) dd[id] = 1'b1;
      for (int k = 0; k < int'($urandom % 3); k++) dd[3'($urandom % 8)] = 1'b1;
      p = ~^dd;
      if (($urandom % 4) == 0) p = ~p;
      run_trial(id, dd, p, 1'($urandom % 2), 1'($urandom % 2), 4'($urandom % 4));
    end

    s0 = n_sel;
    check("R7 random trials produced selections", (s0 > 0) ? 1 : 0, 1);
    done = 1;
    report();
  end
endmodule